// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits between a bus master and a synchronous memory array and turns one externally supplied word address into the array address for each cycle of a four-beat burst. Either of two active-low address strobes starts a burst. One comes from a processor and the other from a cache controller. The processor strobe wins when both strobes arrive together, and it counts only while the primary chip select is asserted. When an honoured strobe arrives, the three chip selects are sampled. If they qualify, the full address is captured and its two low bits seed a two-bit burst counter. If they do not qualify, the block goes to the deselected state.

After the load, an active-low advance input steps the burst one beat per clock. While advance is high the current address is held, which suspends the burst. A static order input selects linear order, in which the low bits count up modulo 4, or interleaved order, in which the low bits are the start value XORed with the beat number. The burst wraps back to its start address after the fourth beat. Downstream control gets three flags that tell it whether the current cycle comes from a load, a step or a hold.

The control is a four-state machine. ST_OFF means deselected. ST_LOAD is the cycle after an external address load. ST_STEP is the cycle after an advance. ST_HOLD is the cycle after a suspend. The transitions are as follows:
- From any state, an honoured strobe with qualifying selects goes to ST_LOAD.
- From any state, an honoured strobe with non-qualifying selects goes to ST_OFF.
- With no honoured strobe, ST_OFF stays in ST_OFF.
- With no honoured strobe, any selected state goes to ST_STEP when advance is low and to ST_HOLD when advance is high.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `active` is 0, all three flags are 0 and `mem_addr` is 0.
- R2: An honoured strobe with qualifying selects (`sel_main_n`=0, `sel_hi`=1, `sel_lo_n`=0) makes the next cycle show `beat_load`=1, `active`=1 and `mem_addr` equal to the sampled `addr_in`. `adv_n` has no effect in that load cycle.
- R3: While `sel_main_n` is 1, the processor strobe `strb_cpu_n` is ignored. If `strb_ctl_n` is also high, no load happens, and the burst steps or holds according to `adv_n`.
- R4: An honoured strobe whose selects do not qualify deselects the block: next cycle `active`=0 and all flags are 0, and `mem_addr` keeps its value.
- R5: When both strobes are low in the same cycle with `sel_main_n`=0, exactly one load of `addr_in` takes place.
- R6: With `order_ilv`=0 (linear), the two low address bits are (start + beats advanced) mod 4. The upper bits stay at the loaded value.
- R7: With `order_ilv`=1 (interleaved), the two low address bits are start XOR beats advanced (mod 4).
- R8: While active with no honoured strobe, `adv_n`=0 at a clock edge advances one beat and sets `beat_step`. After the fourth beat the address wraps back to the start address.
- R9: While active with no honoured strobe, `adv_n`=1 sets `beat_hold` and leaves `mem_addr` unchanged.
- R10: While deselected with no honoured strobe, `adv_n` has no effect: `mem_addr` stays, `active` stays 0 and all flags stay 0.
- R11: At most one of `beat_load`, `beat_step`, `beat_hold` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | ADDR_W | External word address |
| strb_cpu_n | input | 1 | Processor address strobe, active low, has priority |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| sel_main_n | input | 1 | Primary chip select, active low; also gates the processor strobe |
| sel_hi | input | 1 | Expansion chip select, active high |
| sel_lo_n | input | 1 | Expansion chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| mem_addr | output | ADDR_W | Array address for the current cycle |
| active | output | 1 | Block is selected |
| beat_load | output | 1 | Current address came from an external load |
| beat_step | output | 1 | Current address is the next beat of the burst |
| beat_hold | output | 1 | Current address is held from the previous cycle |

## Verification
Two corners are hard to reach from the ports. The first is a processor strobe that is ignored in the middle of a burst. The stimulus first runs a controller-started linear burst well into its beats. It then asserts the processor strobe with the primary select high and the controller strobe idle, once with advance low and once with advance high. The expected step and hold, rather than a reload, show the strobe was ignored. The second corner is the interleaved wrap from a start of 11. The order input is changed only while the block is deselected. A burst is then loaded at a start of 11 and advanced through all four beats and back to the start.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Control states; each names what the current cycle's address is.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,  // deselected
        ST_LOAD = 2'd1,  // external address just captured
        ST_STEP = 2'd2,  // burst advanced one beat
        ST_HOLD = 2'd3   // burst suspended
    } seq_state_e;

    // Width of the wraparound beat counter (four-beat burst).
    localparam int unsigned BEAT_W = 2;

endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb (
    input  logic strb_cpu_n,
    input  logic strb_ctl_n,
    input  logic sel_main_n,
    input  logic sel_hi,
    input  logic sel_lo_n,
    output logic strobe_hit,
    output logic selects_ok
);
    logic cpu_take;
    logic ctl_take;

    always_comb begin
        // Processor strobe counts only while the primary select is low.
        cpu_take   = !strb_cpu_n && !sel_main_n;
        // Controller strobe is considered only when the processor one is not taken.
        ctl_take   = !cpu_take && !strb_ctl_n;
        strobe_hit = cpu_take || ctl_take;
        selects_ok = !sel_main_n && sel_hi && !sel_lo_n;
    end

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen #(
    parameter int unsigned CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_bits,
    input  logic [CNT_W-1:0] beat_num,
    input  logic             order_ilv,
    output logic [CNT_W-1:0] low_bits
);
    logic [CNT_W-1:0] lin_bits;
    logic [CNT_W-1:0] ilv_bits;

    assign lin_bits = start_bits + beat_num;

    for (genvar g = 0; g < CNT_W; g++) begin : g_bit
        assign ilv_bits[g] = start_bits[g] ^ beat_num[g];
        assign low_bits[g] = order_ilv ? ilv_bits[g] : lin_bits[g];
    end

endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_hit,
    input  logic selects_ok,
    input  logic adv_n,
    output logic load_en,
    output logic step_en,
    output logic active,
    output logic beat_load,
    output logic beat_step,
    output logic beat_hold
);
    seq_state_e state_q;
    seq_state_e state_d;
    logic       selected;

    assign selected = (state_q != ST_OFF);

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (strobe_hit && selects_ok) state_d = ST_LOAD;
                else                          state_d = ST_OFF;
            end
            ST_LOAD, ST_STEP, ST_HOLD: begin
                if (strobe_hit)  state_d = selects_ok ? ST_LOAD : ST_OFF;
                else if (!adv_n) state_d = ST_STEP;
                else             state_d = ST_HOLD;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Outputs: datapath enables and per-cycle flags.
    always_comb begin
        load_en   = strobe_hit && selects_ok;
        step_en   = !strobe_hit && selected && !adv_n;
        active    = selected;
        beat_load = 1'b0;
        beat_step = 1'b0;
        beat_hold = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_LOAD: beat_load = 1'b1;
            ST_STEP: beat_step = 1'b1;
            ST_HOLD: beat_hold = 1'b1;
        endcase
    end

    // R4: an honoured strobe with failing selects lands in the deselected state.
    p_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_hit && !selects_ok) |=> (state_q == ST_OFF));

    // R10: deselected with no strobe stays deselected whatever advance does.
    p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !strobe_hit) |=> (state_q == ST_OFF));

endmodule

// File: rtl/burst_addr_regs.sv
module burst_addr_regs #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              step_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int unsigned UP_W = ADDR_W - CNT_W;

    logic [UP_W-1:0]  upper_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] beat_q;
    logic             ilv_q;
    logic [CNT_W-1:0] low_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            beat_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            ilv_q <= order_ilv;
            if (load_en) begin
                upper_q <= addr_in[ADDR_W-1:CNT_W];
                start_q <= addr_in[CNT_W-1:0];
                beat_q  <= '0;
            end else if (step_en) begin
                beat_q  <= beat_q + 1'b1;
            end
        end
    end

    burst_order_gen #(.CNT_W(CNT_W)) order_i (
        .start_bits (start_q),
        .beat_num   (beat_q),
        .order_ilv  (ilv_q),
        .low_bits   (low_bits)
    );

    assign mem_addr = {upper_q, low_bits};

    // R8: the upper address bits change only on a load.
    p_upper_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(upper_q));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              sel_main_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              adv_n,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              active,
    output logic              beat_load,
    output logic              beat_step,
    output logic              beat_hold
);
    localparam int unsigned CNT_W = BEAT_W;

    logic strobe_hit;
    logic selects_ok;
    logic load_en;
    logic step_en;

    burst_strobe_arb arb_i (
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .sel_main_n (sel_main_n),
        .sel_hi     (sel_hi),
        .sel_lo_n   (sel_lo_n),
        .strobe_hit (strobe_hit),
        .selects_ok (selects_ok)
    );

    burst_seq_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_hit (strobe_hit),
        .selects_ok (selects_ok),
        .adv_n      (adv_n),
        .load_en    (load_en),
        .step_en    (step_en),
        .active     (active),
        .beat_load  (beat_load),
        .beat_step  (beat_step),
        .beat_hold  (beat_hold)
    );

    burst_addr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .step_en   (step_en),
        .addr_in   (addr_in),
        .order_ilv (order_ilv),
        .mem_addr  (mem_addr)
    );

    // R2: controller strobe with qualifying selects loads the presented address.
    p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n && !sel_main_n && sel_hi && !sel_lo_n)
        |=> (beat_load && active && mem_addr == $past(addr_in)));

    // R3: processor strobe with primary select high causes no load.
    p_cpu_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_cpu_n && sel_main_n && strb_ctl_n) |=> !beat_load);

    // R9: suspend keeps the address.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && strb_ctl_n && (strb_cpu_n || sel_main_n) && adv_n
         && $stable(order_ilv))
        |=> (beat_hold && $stable(mem_addr)));

    // R8: advance steps the burst within the loaded block.
    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && strb_ctl_n && (strb_cpu_n || sel_main_n) && !adv_n)
        |=> (beat_step && mem_addr[ADDR_W-1:CNT_W] == $past(mem_addr[ADDR_W-1:CNT_W])));

endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
    localparam int ADDR_W = 15;

    typedef struct packed {
        logic [ADDR_W-1:0] a;
        logic [2:0]        f;   // {load, step, hold}
        logic              s;
        logic [7:0]        req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic strb_cpu_n = 1'b1, strb_ctl_n = 1'b1;
    logic sel_main_n = 1'b1, sel_hi = 1'b0, sel_lo_n = 1'b1;
    logic adv_n = 1'b1, order_ilv = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic active, beat_load, beat_step, beat_hold;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    exp_t q[$];

    // Reference model state.
    logic              m_sel = 1'b0;
    logic [ADDR_W-1:0] m_up = '0;
    logic [1:0]        m_start = '0;
    logic [1:0]        m_beat = '0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .sel_main_n(sel_main_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .adv_n(adv_n), .order_ilv(order_ilv), .mem_addr(mem_addr),
        .active(active), .beat_load(beat_load), .beat_step(beat_step),
        .beat_hold(beat_hold)
    );

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic drive(input logic cpu_n, input logic ctl_n, input logic m_n,
                         input logic hi, input logic lo_n, input logic av_n,
                         input logic [ADDR_W-1:0] a, input int req);
        exp_t e;
        logic hit;
        logic [1:0] low;
        @(negedge clk);
        strb_cpu_n = cpu_n; strb_ctl_n = ctl_n; sel_main_n = m_n;
        sel_hi = hi; sel_lo_n = lo_n; adv_n = av_n; addr_in = a;
        hit = (!cpu_n && !m_n) || !ctl_n;
        e.f = 3'b000;
        if (hit) begin
            if (!m_n && hi && !lo_n) begin
                m_sel = 1'b1; m_up = a; m_start = a[1:0]; m_beat = 2'd0;
                e.f = 3'b100;
            end else begin
                m_sel = 1'b0;
            end
        end else if (m_sel) begin
            if (!av_n) begin m_beat = m_beat + 2'd1; e.f = 3'b010; end
            else       e.f = 3'b001;
        end
        low   = order_ilv ? (m_start ^ m_beat) : (m_start + m_beat);
        e.a   = {m_up[ADDR_W-1:2], low};
        e.s   = m_sel;
        e.req = 8'(req);
        q.push_back(e);
    endtask

    // Monitor: compare each result well after the edge that produced it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (mem_addr !== e.a || {beat_load, beat_step, beat_hold} !== e.f
                    || active !== e.s) begin
                    errors++;
                    $display("FAIL R%0d: addr=%h flags=%b active=%b expected addr=%h flags=%b active=%b",
                             e.req, mem_addr, {beat_load, beat_step, beat_hold}, active,
                             e.a, e.f, e.s);
                end
                // R11: never more than one flag.
                checks++;
                if ($countones({beat_load, beat_step, beat_hold}) > 1) begin
                    errors++;
                    $display("FAIL R11: flags=%b expected at most one set",
                             {beat_load, beat_step, beat_hold});
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state before any edge after release.
        checks++;
        if (mem_addr !== '0 || active !== 1'b0 || {beat_load, beat_step, beat_hold} !== 3'b000) begin
            errors++;
            $display("FAIL R1: addr=%h active=%b flags=%b expected 0 0 000",
                     mem_addr, active, {beat_load, beat_step, beat_hold});
        end
        // R10: deselected, advance has no effect.
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 10);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 10);
        // R2: controller load, advance low ignored in the load cycle.
        drive(1, 0, 0, 1, 0, 0, 15'h1235, 2);
        // R6 / R8: linear steps from start 01 with wrap.
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 6);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 6);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 6);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 8);   // R8 wrap to start
        // R9: suspend.
        drive(1, 1, 0, 1, 0, 1, 15'h0000, 9);
        drive(1, 1, 0, 1, 0, 1, 15'h7fff, 9);
        // R3: processor strobe gated by primary select.
        drive(0, 1, 1, 1, 0, 0, 15'h2222, 3);
        drive(0, 1, 1, 1, 0, 1, 15'h2222, 3);
        // R5: both strobes together: a single load.
        drive(0, 0, 0, 1, 0, 0, 15'h0456, 5);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 5);
        // R4: strobe with failing selects deselects; address kept.
        drive(1, 0, 0, 0, 0, 0, 15'h3333, 4);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 10);
        // Order changed only while deselected.
        order_ilv = 1'b1;
        drive(1, 1, 0, 1, 0, 1, 15'h0000, 10);
        // R7: interleaved from start 01.
        drive(0, 1, 0, 1, 0, 1, 15'h7ff1, 2);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 7);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 7);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 7);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 8);
        // R7: interleaved from start 11, full wrap.
        drive(1, 0, 0, 1, 0, 1, 15'h0a0b, 2);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 7);
        drive(1, 1, 0, 1, 0, 1, 15'h0000, 9);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 7);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 7);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 8);
        // R4: deselect through the low-active expansion select, then R10.
        drive(1, 0, 0, 1, 1, 0, 15'h1111, 4);
        drive(1, 1, 0, 1, 0, 0, 15'h0000, 10);
        drive(1, 1, 1, 1, 1, 0, 15'h0000, 10);
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule